// File: doc/BRIEF.md
# I/O Stall and Resume Controller

This block lets a small processor core halt itself while an input or output transfer is pending, and lets the I/O devices restart it. The core raises one general I/O request line and a direction bit. The block turns these into a separate enable for the input device and one for the output device. While the request is up, the block holds a run enable low, and the core's sequencing logic freezes on it.

Each device answers with its own resume line. The block merges these lines into one. A rising edge on the merged line lets the core take exactly one step. That step normally retires the I/O instruction, so the request drops, or the next instruction issues a fresh one.

The stall is a synchronous clock enable in the core's own clock domain. The clock net itself is never gated, so no clipped high phase can reach the core's registers. This matches the rule that a halted clock must rest low.

Top module: `io_stall_ctrl`

## Requirements
- R1: While `rst_n` is low, `run_en` is 1 and both `in_en` and `out_en` are 0.
- R2: In the first cycle after `rst_n` goes high, `run_en` is 1 whatever `io_req` holds, so the core always takes its first step.
- R3: `in_en` is 1 exactly when `rst_n` is high, `io_req` is 1 and `io_dir` is 0 (0 means the input direction).
- R4: `out_en` is 1 exactly when `rst_n` is high, `io_req` is 1 and `io_dir` is 1 (1 means the output direction).
- R5: With `io_req` at 0, both device enables are 0 for either value of `io_dir`, and `run_en` is 1.
- R6: With `io_req` at 1 and no new resume, `run_en` is 0, so the core takes no step for as long as the stall lasts.
- R7: `dev_resume[0]` is the input device's resume and `dev_resume[1]` the output device's. They are ORed into one merged resume. In the cycle the merged resume rises, `run_en` is 1 even with `io_req` at 1.
- R8: A merged resume that stays high grants only one step. Another step needs the merged resume to go low and then rise again.
- R9: Resumes from both devices in the same cycle count as one event and grant one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, free running |
| rst_n | input | 1 | Synchronous reset, active low |
| io_req | input | 1 | General I/O request from the core |
| io_dir | input | 1 | Transfer direction: 0 input, 1 output |
| dev_resume | input | N_DEV | Per-device resume lines, bit 0 input device, bit 1 output device |
| in_en | output | 1 | Input device enable |
| out_en | output | 1 | Output device enable |
| run_en | output | 1 | Clock enable for the core's sequencing registers |

## Verification
A stuck or stale resume-history flop shows at the ports in one of two ways. With a stuck-low history, a held resume grants a second step one cycle after the first. With a stuck-high history, the first resume is lost. Either way it appears at `run_en` within one cycle of a resume edge, and the core step count then differs from the expected count. A start flag that never clears leaves `run_en` high one cycle past reset while a request is pending. A decode fault shows at once on the device enables for one of the four request and direction combinations.

// File: rtl/io_stall_pkg.sv
// Package: shared types for the I/O stall controller.
// Assumes a single-bit transfer direction coded 0 = input, 1 = output.
package io_stall_pkg;

    typedef enum logic {
        XFER_IN  = 1'b0,
        XFER_OUT = 1'b1
    } xfer_dir_e;

    // Number of directions decoded by the enable decoder.
    localparam int unsigned N_DIRS = 2;

    // Returns 1 when the given direction code selects slot idx.
    function automatic logic dir_selects(input xfer_dir_e dir, input int unsigned idx);
        return (idx == 0) ? (dir == XFER_IN) : (dir == XFER_OUT);
    endfunction

endpackage

// File: rtl/io_dir_decode.sv
// Module: io_dir_decode
// Splits the core's general I/O request into one enable per direction.
// Assumes: rst_n is the synchronous active-low reset level, sampled
// combinationally here so the enables stay low for the whole reset.
module io_dir_decode
    import io_stall_pkg::*;
(
    input  logic                rst_n,
    input  logic                io_req,
    input  logic                io_dir,
    output logic [N_DIRS-1:0]   dir_en
);

    xfer_dir_e dir_code;

    // Purpose: cast the raw direction bit to the package type.
    always_comb begin
        dir_code = xfer_dir_e'(io_dir);
    end

    for (genvar gi = 0; gi < N_DIRS; gi++) begin : g_slot
        // Purpose: raise this slot's enable only for an active request in its direction.
        always_comb begin
            dir_en[gi] = rst_n & io_req & dir_selects(dir_code, gi);
        end
    end

endmodule

// File: rtl/resume_merge.sv
// Module: resume_merge
// ORs the resume lines of N_DEV devices and reports the rising edge of
// the merged line as a one-cycle grant.
// Assumes: resume lines are synchronous to clk; the history flop clears
// in reset, so a resume held through reset yields one grant afterwards.
module resume_merge #(
    parameter int unsigned N_DEV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_DEV-1:0]  dev_resume,
    output logic              merged,
    output logic              grant
);

    logic [N_DEV:0] or_chain;
    logic           merged_q;

    assign or_chain[0] = 1'b0;
    for (genvar gd = 0; gd < N_DEV; gd++) begin : g_or
        assign or_chain[gd+1] = or_chain[gd] | dev_resume[gd];
    end

    assign merged = or_chain[N_DEV];

    // Purpose: remember last cycle's merged resume for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) merged_q <= 1'b0;
        else        merged_q <= merged;
    end

    // Purpose: a grant is a merged resume that was low in the previous cycle.
    always_comb begin
        grant = merged & ~merged_q;
    end

endmodule

// File: rtl/run_gate.sv
// Module: run_gate
// Forms the synchronous clock enable for the core's sequencing registers.
// Assumes: the core samples run_en on the rising edge of the same clk.
module run_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic io_req,
    input  logic grant,
    output logic run_en
);

    logic start_q;

    // Purpose: mark the first cycle after reset so the core always starts.
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b1;
        else        start_q <= 1'b0;
    end

    // Purpose: run unless a request is pending with no fresh resume.
    always_comb begin
        if (!rst_n) run_en = 1'b1;
        else        run_en = start_q | grant | ~io_req;
    end

endmodule

// File: rtl/io_stall_ctrl.sv
// Module: io_stall_ctrl (top)
// Halts a core on an I/O request through a clock enable and restarts it
// on a device resume; decodes per-device enables.
// Assumes: one clock domain, synchronous active-low reset.
module io_stall_ctrl #(
    parameter int unsigned N_DEV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_req,
    input  logic             io_dir,
    input  logic [N_DEV-1:0] dev_resume,
    output logic             in_en,
    output logic             out_en,
    output logic             run_en
);
    import io_stall_pkg::*;

    logic [N_DIRS-1:0] dir_en;
    logic              res_merged;
    logic              res_grant;

    io_dir_decode u_decode (
        .rst_n  (rst_n),
        .io_req (io_req),
        .io_dir (io_dir),
        .dir_en (dir_en)
    );

    resume_merge #(.N_DEV(N_DEV)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .dev_resume (dev_resume),
        .merged     (res_merged),
        .grant      (res_grant)
    );

    run_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .io_req (io_req),
        .grant  (res_grant),
        .run_en (run_en)
    );

    assign in_en  = dir_en[XFER_IN];
    assign out_en = dir_en[XFER_OUT];

endmodule

// File: rtl/io_stall_ctrl_chk.sv
// Module: io_stall_ctrl_chk
// Port-level properties of io_stall_ctrl, attached with bind.
module io_stall_ctrl_chk #(
    parameter int unsigned N_DEV = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             io_req,
    input logic             io_dir,
    input logic [N_DEV-1:0] dev_resume,
    input logic             in_en,
    input logic             out_en,
    input logic             run_en
);

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |-> (run_en && !in_en && !out_en));

    a_r3_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_en && out_en));

    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !io_req |-> (!in_en && !out_en && run_en));

    a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && io_req && (dev_resume == '0)) |-> !run_en);

    a_r7_edge_grants: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (dev_resume != '0) && ($past(dev_resume) == '0)) |-> run_en);

    a_r8_held_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && io_req && (dev_resume != '0) && ($past(dev_resume) != '0)) |-> !run_en);

endmodule

bind io_stall_ctrl io_stall_ctrl_chk #(.N_DEV(N_DEV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_req     (io_req),
    .io_dir     (io_dir),
    .dev_resume (dev_resume),
    .in_en      (in_en),
    .out_en     (out_en),
    .run_en     (run_en)
);

// File: tb/io_stall_ctrl_bench.sv
module io_stall_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // Vector fields: {io_req, io_dir, res1, res0, exp_in, exp_out, exp_run}
    localparam logic [6:0] VEC [NVEC] = '{
        7'b0000_001,  // R5 idle, dir 0
        7'b0100_001,  // R5 idle, dir 1
        7'b1000_100,  // R3 input request stalls (R6)
        7'b1100_010,  // R4 output request stalls (R6)
        7'b1001_101,  // R7 input device resume edge
        7'b1001_100,  // R8 held resume, no step
        7'b1100_010,  // R6 released, still stalled
        7'b1110_011,  // R7 output device resume edge
        7'b1111_010,  // R8 merged stays high
        7'b1100_010,  // R6
        7'b1111_011,  // R9 both together, one edge
        7'b0000_001   // R5 request dropped
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       io_req;
    logic       io_dir;
    logic [1:0] dev_resume;
    logic       in_en, out_en, run_en;

    int checks = 0;
    int fails  = 0;
    int steps  = 0;
    bit done   = 1'b0;

    io_stall_ctrl u_io_stall_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_req     (io_req),
        .io_dir     (io_dir),
        .dev_resume (dev_resume),
        .in_en      (in_en),
        .out_en     (out_en),
        .run_en     (run_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Core model: one step per rising edge with run_en high out of reset.
    always @(posedge clk) if (rst_n && run_en) steps <= steps + 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int s0;
        rst_n = 1'b0; io_req = 1'b1; io_dir = 1'b0; dev_resume = 2'b00;
        repeat (3) @(negedge clk);
        #1;
        check("R1 run_en", run_en, 1);
        check("R1 in_en", in_en, 0);
        check("R1 out_en", out_en, 0);

        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R2 run_en first cycle", run_en, 1);
        check("R3 in_en", in_en, 1);
        @(negedge clk);
        #1;
        check("R6 run_en after start", run_en, 0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {io_req, io_dir, dev_resume} = VEC[i][6:3];
            #1;
            check($sformatf("R3 in_en vec %0d", i), in_en, VEC[i][2]);
            check($sformatf("R4 out_en vec %0d", i), out_en, VEC[i][1]);
            check($sformatf("R7 run_en vec %0d", i), run_en, VEC[i][0]);
        end

        // R6: long stall takes no step
        @(negedge clk);
        io_req = 1'b1; io_dir = 1'b1; dev_resume = 2'b00;
        s0 = steps;
        repeat (20) @(negedge clk);
        check("R6 steps during stall", steps, s0);

        // R8: held input resume grants one step
        dev_resume = 2'b01;
        repeat (5) @(negedge clk);
        check("R8 steps for held resume", steps, s0 + 1);
        dev_resume = 2'b00;
        repeat (2) @(negedge clk);
        check("R8 no step after release", steps, s0 + 1);

        // R9: both devices together grant one step
        dev_resume = 2'b11;
        repeat (3) @(negedge clk);
        check("R9 steps for joint resume", steps, s0 + 2);
        dev_resume = 2'b10;
        repeat (2) @(negedge clk);
        check("R9 partial drop gives no step", steps, s0 + 2);

        // R5: idle with dir 1, core runs every cycle
        dev_resume = 2'b00; io_req = 1'b0;
        s0 = steps;
        repeat (4) @(negedge clk);
        check("R5 free running steps", steps, s0 + 4);

        // R1/R2: reset with resume held, then request pending
        rst_n = 1'b0; io_req = 1'b1; io_dir = 1'b0; dev_resume = 2'b01;
        #1;
        check("R1 enables in reset", int'({in_en, out_en}), 0);
        @(negedge clk);
        rst_n = 1'b1; dev_resume = 2'b00;
        #1;
        check("R2 run after second reset", run_en, 1);

        finish_run();
    end

endmodule